// File: doc/BRIEF.md
# Inter-Packet Gap Enforcer

This block keeps Ethernet frames spaced apart on both sides of a MAC. On the transmit side it counts bit times once a frame has finished. It releases the next frame only when that count reaches the gap that applies. A frame that was already queued when its predecessor ended is "back to back". Back-to-back frames, and every frame in full duplex, use one programmed gap. A frame sent in half duplex after an idle pause uses a second programmed gap. On the receive side the block measures how many bit times the line stayed idle before each incoming frame. It flags for dropping any frame that followed too short a gap.

The MAC supplies a strobe that marks each bit time, along with the transmit and receive frame-active levels, a duplex select and three 7-bit gap values. A value of 96 is the usual setting for both transmit gaps, and 80 is the usual setting for the receive minimum. The block drives one grant level, which the transmitter waits on, and one drop pulse, which the receive path uses to discard the frame that is just starting.

Top module: `ipg_guard`

## Requirements
- R1: After reset `tx_grant` is 1 while `tx_active` is 0, and `rx_drop` is 0.
- R2: With `full_duplex` = 1, the transmit gap is always `gap_b2b`, whatever `tx_req` was when the frame ended.
- R3: With `full_duplex` = 0 and `tx_req` = 1 in the last cycle of `tx_active`, the next gap is `gap_b2b`.
- R4: With `full_duplex` = 0 and `tx_req` = 0 in the last cycle of `tx_active`, the next gap is `gap_nb2b`.
- R5: `tx_grant` is 0 while `tx_active` is 1. After a frame, `tx_grant` is 1 exactly when the number of cycles with `bit_tick` = 1 and `tx_active` = 0 is at least the selected gap. Cycles without `bit_tick` do not count.
- R6: A receive frame starts in the first cycle with `rx_active` = 1. If fewer than `gap_rx_min` ticked idle cycles preceded it, `rx_drop` is 1 for exactly the one following cycle.
- R7: A receive frame preceded by a ticked idle count equal to or above `gap_rx_min` is not flagged.
- R8: The first receive frame after reset is never flagged, even when no idle time preceded it.
- R9: Both idle counts saturate at 127, so an idle period of any length satisfies any gap up to 127 and never wraps.
- R10: A selected transmit gap of 0 gives `tx_grant` = 1 in the first cycle with `tx_active` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| gap_b2b | input | 7 | Back-to-back transmit gap in bit times |
| gap_nb2b | input | 7 | Half-duplex non-back-to-back transmit gap in bit times |
| gap_rx_min | input | 7 | Minimum accepted receive gap in bit times |
| tx_req | input | 1 | A further transmit frame is queued |
| tx_active | input | 1 | A transmit frame is on the line |
| tx_grant | output | 1 | The next transmit frame may start |
| rx_active | input | 1 | A receive frame is on the line |
| rx_drop | output | 1 | One-cycle pulse: drop the frame now starting |

## Verification
`tx_grant` is combinational from `tx_active` and a registered count. It is therefore due in the same cycle as the inputs that produce it, and counts only the ticks taken at earlier clock edges. `rx_drop` is due one cycle after the first `rx_active` cycle. The driver applies each input set 1 ns after a rising edge and queues the outputs expected for that cycle. The monitor compares them at the following falling edge, before the next edge can move any register. The expected values come from a bench-side count of ticked idle cycles taken from the requirements.

// File: rtl/ipg_guard.sv
module ipg_guard #(
  parameter int GW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          full_duplex,
  input  logic [GW-1:0] gap_b2b,
  input  logic [GW-1:0] gap_nb2b,
  input  logic [GW-1:0] gap_rx_min,
  input  logic          tx_req,
  input  logic          tx_active,
  output logic          tx_grant,
  input  logic          rx_active,
  output logic          rx_drop
);
  localparam logic [GW-1:0] SAT = '1;

  logic [GW-1:0] tx_cnt, rx_cnt, tx_gap;
  logic          tx_b2b, rx_prev, rx_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt <= SAT;
      tx_b2b <= 1'b0;
    end else if (tx_active) begin
      tx_cnt <= '0;
      tx_b2b <= tx_req;
    end else if (bit_tick && tx_cnt != SAT) begin
      tx_cnt <= tx_cnt + 1'b1;
    end
  end

  assign tx_gap   = (full_duplex || tx_b2b) ? gap_b2b : gap_nb2b;
  assign tx_grant = !tx_active && (tx_cnt >= tx_gap);

  assign rx_start = rx_active && !rx_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt  <= SAT;
      rx_prev <= 1'b0;
      rx_drop <= 1'b0;
    end else begin
      rx_prev <= rx_active;
      rx_drop <= rx_start && (rx_cnt < gap_rx_min);
      if (rx_active)
        rx_cnt <= '0;
      else if (bit_tick && rx_cnt != SAT)
        rx_cnt <= rx_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ipg_guard_sva.sv
module ipg_guard_sva #(
  parameter int GW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          full_duplex,
  input logic [GW-1:0] gap_b2b,
  input logic [GW-1:0] gap_nb2b,
  input logic          tx_active,
  input logic          tx_grant,
  input logic          rx_active,
  input logic          rx_drop
);
  p_no_grant_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !tx_grant);

  p_grant_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_grant) && !tx_active && !$past(tx_active) && $stable(full_duplex)
     && $stable(gap_b2b) && $stable(gap_nb2b)) |-> $past(bit_tick));

  p_grant_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_grant) && !tx_active && !$past(tx_active) && $stable(full_duplex)
     && $stable(gap_b2b) && $stable(gap_nb2b)) |-> tx_grant);

  p_drop_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> !rx_drop);

  p_drop_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> ($past(rx_active) && !$past(rx_active, 2)));
endmodule

bind ipg_guard ipg_guard_sva #(.GW(GW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .full_duplex(full_duplex),
  .gap_b2b(gap_b2b), .gap_nb2b(gap_nb2b), .tx_active(tx_active),
  .tx_grant(tx_grant), .rx_active(rx_active), .rx_drop(rx_drop)
);

// File: tb/ipg_guard_test.sv
module ipg_guard_test;
  logic clk = 0, rst_n = 0;
  logic tk = 0, fd = 0, tr = 0, ta = 0, ra = 0;
  logic [6:0] gb = 7'd12, gn = 7'd20, gm = 7'd10;
  logic grant, drop;

  typedef struct { logic g; logic d; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  int mtx = 127, mrx = 127;
  logic mb2b = 0, mra = 0, mdrop = 0;

  always #4 clk = ~clk;

  ipg_guard uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(tk), .full_duplex(fd),
    .gap_b2b(gb), .gap_nb2b(gn), .gap_rx_min(gm), .tx_req(tr),
    .tx_active(ta), .tx_grant(grant), .rx_active(ra), .rx_drop(drop)
  );

  task automatic upd();
    mdrop = ra && !mra && (mrx < int'(gm));
    if (ta) begin mtx = 0; mb2b = tr; end
    else if (tk && mtx != 127) mtx++;
    if (ra) mrx = 0;
    else if (tk && mrx != 127) mrx++;
    mra = ra;
  endtask

  task automatic expect_now(input string tag);
    item_t it;
    int sel;
    sel = (fd || mb2b) ? int'(gb) : int'(gn);
    it.g = !ta && (mtx >= sel);
    it.d = mdrop;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cyc(input logic ta_i, tr_i, tk_i, ra_i, input string tag);
    @(posedge clk);
    upd();
    #1;
    ta = ta_i; tr = tr_i; tk = tk_i; ra = ra_i;
    expect_now(tag);
  endtask

  task automatic cfg(input logic f, input logic [6:0] b, n, m, input string tag);
    @(posedge clk);
    upd();
    #1;
    ta = 0; tr = 0; tk = 0; ra = 0;
    fd = f; gb = b; gn = n; gm = m;
    expect_now(tag);
  endtask

  task automatic idle(input int n, input int every, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, (i % every) == 0, 0, tag);
  endtask

  task automatic txf(input int len, input logic req, input string tag);
    for (int i = 0; i < len; i++) cyc(1, (i == len - 1) ? req : 1'b0, 1, 0, tag);
  endtask

  task automatic rxf(input int len, input string tag);
    for (int i = 0; i < len; i++) cyc(0, 0, 1, 1, tag);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks += 2;
      if (grant !== it.g) begin
        fails++;
        $display("FAIL %s tx_grant actual %b expected %b", it.tag, grant, it.g);
      end
      if (drop !== it.d) begin
        fails++;
        $display("FAIL %s rx_drop actual %b expected %b", it.tag, drop, it.d);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expect_now("R1");
    idle(2, 1, "R1");
    rxf(3, "R8");
    idle(5, 1, "R6");
    rxf(3, "R6");
    idle(10, 1, "R7");
    rxf(3, "R7");
    idle(9, 1, "R6");
    rxf(2, "R6");
    txf(4, 0, "R5");
    idle(50, 2, "R4");
    txf(4, 1, "R3");
    idle(40, 1, "R3");
    cfg(1, 7'd12, 7'd20, 7'd10, "R2");
    txf(4, 0, "R2");
    idle(30, 3, "R2");
    cfg(0, 7'd12, 7'd0, 7'd10, "R10");
    txf(3, 0, "R10");
    idle(3, 1, "R10");
    cfg(0, 7'd96, 7'd96, 7'd80, "R4");
    txf(2, 0, "R4");
    rxf(2, "R7");
    idle(79, 1, "R6");
    rxf(2, "R6");
    idle(80, 1, "R7");
    rxf(2, "R7");
    idle(30, 1, "R4");
    cfg(1, 7'd127, 7'd20, 7'd127, "R9");
    txf(2, 0, "R9");
    rxf(2, "R9");
    idle(200, 1, "R9");
    rxf(2, "R9");
    idle(126, 1, "R9");
    rxf(2, "R9");
    idle(3, 1, "R9");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule